// File: doc/BRIEF.md
# Function-Unit Dependency Matrix Scoreboard

This block tracks issue and hazards for a small out-of-order core. Each function unit owns one row of single-bit cells. The row records which other units must write before this unit may read its operands (read-after-write). It also records which older units must read before this unit may write its result (write-after-read). All hazard detection is done by AND/OR reduction of these bits and of one-hot register vectors. There is no multi-bit tag compare against a destination register. Each unit gets its own read grant and its own write grant, so an instruction can read and execute while its result write is still held back.

Speculation lines act like extra function units whose only job is to cast a shadow. When an instruction issues, it picks up a shadow bit for every speculation line that is open at that moment. A shadowed unit may read and execute, but it may not write. When the line passes, the shadow bits drop and the write may go ahead. When the line is cancelled, every unit shadowed by it is freed with no write. A per-unit exception hold input uses the same gating on the write grant.

Top module: `fu_dep_scoreboard`

## Requirements
- R1: After reset no unit is busy, no speculation line is live, both grant vectors are zero, and `iss_ready` is 1.
- R2: An issue is accepted in a cycle when `iss_valid` and `iss_ready` are both 1. The target unit's `unit_busy` bit is 1 from the next cycle. `iss_ready` is 0 while the target unit (`iss_unit`, binary index) is busy.
- R3: `iss_ready` is 0 while any busy unit holds the same destination register as `iss_dst` (write-after-write stall).
- R4: `go_read[i]` is 1 in the first cycle, from the cycle after issue on, in which no unit recorded as a producer of one of unit i's sources is still unwritten. It is 1 for exactly one cycle per issue.
- R5: `go_write[i]` needs all of the following: unit i has had its read grant in an earlier cycle, `wr_req[i]` is 1, and nothing in R6, R7, R9 or R10 blocks it. Unit i is free in the cycle after `go_write[i]`.
- R6: `go_write[i]` is withheld while any unit that was busy and had not yet read at unit i's issue still has not been granted its read, when one of that unit's sources equals unit i's destination.
- R7: `spec_open[k]` makes line k live from the next cycle. An instruction issued while line k is live, and not resolving in that same cycle, carries shadow k. A shadowed unit gets `go_read` as normal but never `go_write`.
- R8: `spec_pass[k]` on a live line clears shadow k from all units and makes the line not live from the next cycle.
- R9: `spec_kill[k]` frees every unit shadowed by line k in the next cycle, with no `go_write`. Those units show no `go_read` or `go_write` in the kill cycle, and the line stops being live.
- R10: `exc_hold[i]` blocks only `go_write[i]`. It has no effect on reads or on other units.
- R11: In the cycle of a producer's `go_write`, a dependent unit's read is granted at the earliest in the next cycle. An instruction issued in that same cycle records no dependency on the writing unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_unit | input | 2 | Target function unit index |
| iss_dst | input | 4 | Destination register |
| iss_srca | input | 4 | First source register |
| iss_srcb | input | 4 | Second source register |
| iss_ready | output | 1 | Issue may be accepted this cycle |
| spec_open | input | 2 | Open speculation line |
| spec_pass | input | 2 | Resolve speculation line as correct |
| spec_kill | input | 2 | Resolve speculation line as wrong, cancel shadowed units |
| exc_hold | input | 4 | Per-unit exception shadow, blocks write |
| wr_req | input | 4 | Unit has its result and asks to write |
| go_read | output | 4 | Per-unit operand read grant |
| go_write | output | 4 | Per-unit result write grant |
| unit_busy | output | 4 | One-hot-per-unit busy vector |
| spec_live | output | 2 | Speculation lines currently open |

## Verification
The embedded assertions check on every cycle that no two busy units share a destination register and that a read grant never repeats for one issue. They also check that a unit is busy after it is loaded and free after it writes or is cancelled, and that a resolved speculation line is closed. Only the bench's scenarios can show that the grant timing is right under chained read-after-write and write-after-read dependencies, and that cancel frees exactly the shadowed units. The same holds for the exception hold staying local to its unit and for an issue in a producer's write cycle taking no dependency. The bench checks these against a reference model driven by a long run of random issues, resolutions and write requests.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_NFU   = 4;
  localparam int SB_NSPEC = 2;
  localparam int SB_NREG  = 16;
endpackage

// File: rtl/sb_spec_lines.sv
module sb_spec_lines #(
  parameter int NSPEC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSPEC-1:0] open_i,
  input  logic [NSPEC-1:0] pass_i,
  input  logic [NSPEC-1:0] kill_i,
  output logic [NSPEC-1:0] live_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) live_o <= '0;
    else        live_o <= (live_o | open_i) & ~(pass_i | kill_i);
  end

  for (genvar k = 0; k < NSPEC; k++) begin : g_chk
    AST_LINE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_i[k] || kill_i[k]) |=> !live_o[k]); // R8
  end
endmodule

// File: rtl/sb_hazard_scan.sv
module sb_hazard_scan #(
  parameter int NFU  = 4,
  parameter int NREG = 16,
  localparam int FUW = $clog2(NFU)
) (
  input  logic [NFU-1:0]           busy_i,
  input  logic [NFU-1:0]           rd_pend_i,
  input  logic [NFU-1:0]           go_rd_i,
  input  logic [NFU-1:0]           go_wr_i,
  input  logic [NFU-1:0]           kill_i,
  input  logic [NFU-1:0][NREG-1:0] dst_oh_i,
  input  logic [NFU-1:0][NREG-1:0] src_oh_i,
  input  logic [FUW-1:0]           new_unit_i,
  input  logic [NREG-1:0]          new_dst_oh_i,
  input  logic [NREG-1:0]          new_src_oh_i,
  output logic                     ready_o,
  output logic [NFU-1:0]           raw_row_o,
  output logic [NFU-1:0]           war_row_o
);
  logic [NFU-1:0] waw_hit;

  always_comb begin
    for (int j = 0; j < NFU; j++) begin
      waw_hit[j]   = busy_i[j] & (|(dst_oh_i[j] & new_dst_oh_i));
      raw_row_o[j] = busy_i[j] & ~go_wr_i[j] & ~kill_i[j]
                     & (|(dst_oh_i[j] & new_src_oh_i));
      war_row_o[j] = rd_pend_i[j] & ~go_rd_i[j] & ~kill_i[j]
                     & (|(src_oh_i[j] & new_dst_oh_i));
    end
    ready_o = ~busy_i[new_unit_i] & ~(|waw_hit);
  end
endmodule

// File: rtl/sb_fu_row.sv
module sb_fu_row #(
  parameter int NFU   = 4,
  parameter int NSPEC = 2,
  parameter int NREG  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NREG-1:0]  load_dst_oh_i,
  input  logic [NREG-1:0]  load_src_oh_i,
  input  logic [NFU-1:0]   load_raw_i,
  input  logic [NFU-1:0]   load_war_i,
  input  logic [NSPEC-1:0] load_shadow_i,
  input  logic [NFU-1:0]   clr_raw_i,
  input  logic [NFU-1:0]   clr_war_i,
  input  logic [NSPEC-1:0] spec_pass_i,
  input  logic [NSPEC-1:0] spec_kill_i,
  input  logic             exc_hold_i,
  input  logic             wr_req_i,
  output logic             busy_o,
  output logic             rd_pend_o,
  output logic             go_rd_o,
  output logic             go_wr_o,
  output logic             kill_o,
  output logic [NREG-1:0]  dst_oh_o,
  output logic [NREG-1:0]  src_oh_o
);
  logic             rd_done;
  logic [NFU-1:0]   raw_q, war_q;
  logic [NSPEC-1:0] shadow_q;

  assign kill_o    = busy_o & (|(shadow_q & spec_kill_i));
  assign rd_pend_o = busy_o & ~rd_done;
  assign go_rd_o   = rd_pend_o & ~(|raw_q) & ~kill_o;
  assign go_wr_o   = busy_o & rd_done & wr_req_i & ~(|shadow_q)
                     & ~exc_hold_i & ~(|war_q) & ~kill_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      rd_done  <= 1'b0;
      raw_q    <= '0;
      war_q    <= '0;
      shadow_q <= '0;
      dst_oh_o <= '0;
      src_oh_o <= '0;
    end else if (load_i) begin
      busy_o   <= 1'b1;
      rd_done  <= 1'b0;
      raw_q    <= load_raw_i;
      war_q    <= load_war_i;
      shadow_q <= load_shadow_i;
      dst_oh_o <= load_dst_oh_i;
      src_oh_o <= load_src_oh_i;
    end else begin
      if (go_wr_o || kill_o) busy_o <= 1'b0;
      if (go_rd_o) rd_done <= 1'b1;
      raw_q    <= raw_q & ~clr_raw_i;
      war_q    <= war_q & ~clr_war_i;
      shadow_q <= shadow_q & ~spec_pass_i;
    end
  end

  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_o); // R2
  AST_READ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    go_rd_o |=> !go_rd_o); // R4
  AST_FREE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr_o |=> !busy_o); // R5
  AST_FREE_AFTER_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    kill_o |=> !busy_o); // R9
endmodule

// File: rtl/fu_dep_scoreboard.sv
module fu_dep_scoreboard #(
  parameter int NFU   = sb_pkg::SB_NFU,
  parameter int NSPEC = sb_pkg::SB_NSPEC,
  parameter int NREG  = sb_pkg::SB_NREG,
  localparam int FUW  = $clog2(NFU),
  localparam int RW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [FUW-1:0]   iss_unit,
  input  logic [RW-1:0]    iss_dst,
  input  logic [RW-1:0]    iss_srca,
  input  logic [RW-1:0]    iss_srcb,
  output logic             iss_ready,
  input  logic [NSPEC-1:0] spec_open,
  input  logic [NSPEC-1:0] spec_pass,
  input  logic [NSPEC-1:0] spec_kill,
  input  logic [NFU-1:0]   exc_hold,
  input  logic [NFU-1:0]   wr_req,
  output logic [NFU-1:0]   go_read,
  output logic [NFU-1:0]   go_write,
  output logic [NFU-1:0]   unit_busy,
  output logic [NSPEC-1:0] spec_live
);
  localparam logic [NREG-1:0] ONE_REG = NREG'(1);

  logic [NREG-1:0]           new_dst_oh, new_src_oh;
  logic [NFU-1:0]            rd_pend, kill, raw_row, war_row, clr_raw, clr_war;
  logic [NFU-1:0][NREG-1:0]  dst_oh, src_oh;
  logic [NSPEC-1:0]          new_shadow;
  logic                      iss_fire;

  assign new_dst_oh = ONE_REG << iss_dst;
  assign new_src_oh = (ONE_REG << iss_srca) | (ONE_REG << iss_srcb);
  assign iss_fire   = iss_valid & iss_ready;
  assign new_shadow = spec_live & ~spec_pass & ~spec_kill;
  assign clr_raw    = go_write | kill;
  assign clr_war    = go_read | kill;

  sb_spec_lines #(.NSPEC(NSPEC)) u_spec (
    .clk(clk), .rst_n(rst_n), .open_i(spec_open), .pass_i(spec_pass),
    .kill_i(spec_kill), .live_o(spec_live)
  );

  sb_hazard_scan #(.NFU(NFU), .NREG(NREG)) u_scan (
    .busy_i(unit_busy), .rd_pend_i(rd_pend), .go_rd_i(go_read),
    .go_wr_i(go_write), .kill_i(kill), .dst_oh_i(dst_oh), .src_oh_i(src_oh),
    .new_unit_i(iss_unit), .new_dst_oh_i(new_dst_oh),
    .new_src_oh_i(new_src_oh), .ready_o(iss_ready),
    .raw_row_o(raw_row), .war_row_o(war_row)
  );

  for (genvar i = 0; i < NFU; i++) begin : g_row
    sb_fu_row #(.NFU(NFU), .NSPEC(NSPEC), .NREG(NREG)) u_row (
      .clk(clk), .rst_n(rst_n),
      .load_i(iss_fire && (iss_unit == FUW'(i))),
      .load_dst_oh_i(new_dst_oh), .load_src_oh_i(new_src_oh),
      .load_raw_i(raw_row), .load_war_i(war_row), .load_shadow_i(new_shadow),
      .clr_raw_i(clr_raw), .clr_war_i(clr_war),
      .spec_pass_i(spec_pass), .spec_kill_i(spec_kill),
      .exc_hold_i(exc_hold[i]), .wr_req_i(wr_req[i]),
      .busy_o(unit_busy[i]), .rd_pend_o(rd_pend[i]), .go_rd_o(go_read[i]),
      .go_wr_o(go_write[i]), .kill_o(kill[i]),
      .dst_oh_o(dst_oh[i]), .src_oh_o(src_oh[i])
    );
    for (genvar j = i + 1; j < NFU; j++) begin : g_pair
      AST_NO_SHARED_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_busy[i] && unit_busy[j]) |-> ((dst_oh[i] & dst_oh[j]) == '0)); // R3
    end
  end
endmodule

// File: tb/fu_dep_scoreboard_bench.sv
`timescale 1ns/1ps
module fu_dep_scoreboard_bench;
  localparam int NFU = 4, NSPEC = 2;
  logic clk = 0, rst_n = 0;
  logic iss_valid = 0;
  logic [1:0] iss_unit = 0;
  logic [3:0] iss_dst = 0, iss_srca = 0, iss_srcb = 0;
  logic [1:0] spec_open = 0, spec_pass = 0, spec_kill = 0;
  logic [3:0] exc_hold = 0, wr_req = 0;
  logic iss_ready;
  logic [3:0] go_read, go_write, unit_busy;
  logic [1:0] spec_live;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  fu_dep_scoreboard u_fu_dep_scoreboard (.*);

  // reference state
  bit m_busy[NFU], m_rd[NFU];
  int m_dst[NFU], m_sa[NFU], m_sb[NFU];
  bit m_raw[NFU][NFU], m_war[NFU][NFU], m_sh[NFU][NSPEC];
  bit m_live[NSPEC];

  function automatic bit has_any_raw(int u);
    for (int j = 0; j < NFU; j++) if (m_raw[u][j]) return 1;
    return 0;
  endfunction
  function automatic bit has_any_war(int u);
    for (int j = 0; j < NFU; j++) if (m_war[u][j]) return 1;
    return 0;
  endfunction
  function automatic bit shadowed(int u);
    for (int k = 0; k < NSPEC; k++) if (m_sh[u][k]) return 1;
    return 0;
  endfunction
  function automatic bit exp_kill(int u);
    for (int k = 0; k < NSPEC; k++) if (m_busy[u] && m_sh[u][k] && spec_kill[k]) return 1;
    return 0;
  endfunction
  function automatic bit exp_ready();
    if (m_busy[iss_unit]) return 0;
    for (int j = 0; j < NFU; j++) if (m_busy[j] && m_dst[j] == int'(iss_dst)) return 0;
    return 1;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic step();
    bit kl[NFU], gr[NFU], gw[NFU], rdy;
    bit nraw[NFU], nwar[NFU], nsh[NSPEC];
    logic [3:0] e_rd, e_wr, e_busy;
    logic [1:0] e_live;
    int u;
    #1;
    rdy = exp_ready();
    for (int i = 0; i < NFU; i++) begin
      kl[i] = exp_kill(i);
      gr[i] = m_busy[i] && !m_rd[i] && !has_any_raw(i) && !kl[i];
      gw[i] = m_busy[i] && m_rd[i] && wr_req[i] && !shadowed(i) && !exc_hold[i]
              && !has_any_war(i) && !kl[i];
      e_rd[i] = gr[i]; e_wr[i] = gw[i]; e_busy[i] = m_busy[i];
    end
    for (int k = 0; k < NSPEC; k++) e_live[k] = m_live[k];
    check("R2 R3 iss_ready", iss_ready, rdy);
    check("R4 R11 go_read", go_read, e_rd);
    check("R5 R6 R7 R10 go_write", go_write, e_wr);
    check("R2 R5 R9 unit_busy", unit_busy, e_busy);
    check("R7 R8 spec_live", spec_live, e_live);
    // issue capture from current state
    u = iss_unit;
    for (int j = 0; j < NFU; j++) begin
      nraw[j] = m_busy[j] && !gw[j] && !kl[j] && (m_dst[j] == int'(iss_srca) || m_dst[j] == int'(iss_srcb));
      nwar[j] = m_busy[j] && !m_rd[j] && !gr[j] && !kl[j] && (m_sa[j] == int'(iss_dst) || m_sb[j] == int'(iss_dst));
    end
    for (int k = 0; k < NSPEC; k++) nsh[k] = m_live[k] && !spec_pass[k] && !spec_kill[k];
    // state update
    for (int i = 0; i < NFU; i++) begin
      if (kl[i] || gw[i]) m_busy[i] = 0;
      if (gr[i]) m_rd[i] = 1;
      for (int j = 0; j < NFU; j++) begin
        if (gw[j] || kl[j]) m_raw[i][j] = 0;
        if (gr[j] || kl[j]) m_war[i][j] = 0;
      end
      for (int k = 0; k < NSPEC; k++) if (spec_pass[k]) m_sh[i][k] = 0;
    end
    for (int k = 0; k < NSPEC; k++)
      m_live[k] = (m_live[k] || spec_open[k]) && !spec_pass[k] && !spec_kill[k];
    if (iss_valid && rdy) begin
      m_busy[u] = 1; m_rd[u] = 0;
      m_dst[u] = iss_dst; m_sa[u] = iss_srca; m_sb[u] = iss_srcb;
      for (int j = 0; j < NFU; j++) begin m_raw[u][j] = nraw[j]; m_war[u][j] = nwar[j]; end
      for (int k = 0; k < NSPEC; k++) m_sh[u][k] = nsh[k];
    end
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid = 0; spec_open = 0; spec_pass = 0; spec_kill = 0; exc_hold = 0; wr_req = 0;
  endtask

  task automatic issue(input int u, input int d, input int a, input int b);
    iss_valid = 1; iss_unit = 2'(u); iss_dst = 4'(d); iss_srca = 4'(a); iss_srcb = 4'(b);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R1..: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    for (int i = 0; i < NFU; i++) begin
      m_busy[i] = 0; m_rd[i] = 0; m_dst[i] = 0; m_sa[i] = 0; m_sb[i] = 0;
      for (int j = 0; j < NFU; j++) begin m_raw[i][j] = 0; m_war[i][j] = 0; end
      for (int k = 0; k < NSPEC; k++) m_sh[i][k] = 0;
    end
    for (int k = 0; k < NSPEC; k++) m_live[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    check("R1 busy", unit_busy, 0);
    check("R1 grants", {go_read, go_write}, 0);
    check("R1 live", spec_live, 0);
    check("R1 ready", iss_ready, 1);
    @(negedge clk);
    // directed: RAW chain with write-through (R4 R11)
    issue(0, 3, 1, 2); step();
    issue(1, 4, 3, 3); wr_req = 4'b0001; step();
    idle(); wr_req = 4'b0001; step();
    check("R11 dep read after producer write", go_read[1], 1);
    idle(); step();
    // directed: WAW stall (R3)
    issue(2, 4, 0, 0); step();
    idle(); wr_req = 4'b0010; step(); idle(); step(); step();
    // directed: WAR hold (R6)
    issue(0, 5, 7, 7); step();
    issue(1, 7, 1, 1); wr_req = 4'b0010; step();
    idle(); wr_req = 4'b0011; step(); step(); step(); idle(); step();
    // directed: shadow then pass (R7 R8)
    spec_open = 2'b01; step(); idle();
    issue(2, 8, 1, 1); step();
    idle(); wr_req = 4'b0100; step(); step();
    check("R7 shadowed write withheld", go_write[2], 0);
    spec_pass = 2'b01; wr_req = 4'b0100; step();
    idle(); wr_req = 4'b0100; step(); idle(); step();
    // directed: shadow then kill (R9), exception hold (R10)
    spec_open = 2'b10; step(); idle();
    issue(3, 9, 2, 2); step();
    idle(); step();
    spec_kill = 2'b10; step(); idle();
    check("R9 cancelled unit freed", unit_busy[3], 0);
    issue(0, 10, 1, 1); step(); idle(); step();
    exc_hold = 4'b0001; wr_req = 4'b0001; step(); step();
    exc_hold = 0; step(); idle(); step();
    // random phase
    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom % 2 == 0) issue($urandom % 4, $urandom % 6, $urandom % 6, $urandom % 6);
      wr_req = 4'($urandom);
      exc_hold = ($urandom % 8 == 0) ? 4'($urandom) : 4'b0;
      for (int k = 0; k < NSPEC; k++) begin
        if (!m_live[k] && $urandom % 16 == 0) spec_open[k] = 1;
        if (m_live[k] && $urandom % 20 == 0) spec_pass[k] = 1;
        else if (m_live[k] && $urandom % 24 == 0) spec_kill[k] = 1;
      end
      step();
    end
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule